// File: doc/BRIEF.md
# Timer Counter Channel with Compare

This block is one timer/counter channel in waveform mode. A 16-bit counter advances on a selectable count tick. The tick can come from one of four power-of-two taps of a prescaler running on the system clock, from the system clock itself, from a slow-clock tick pulse, or from rising edges of an asynchronous external input. Compare registers A and C watch the counter. Each compare drives a waveform output pin through its own set/clear/toggle action and raises a latched status flag. The status flags feed an interrupt line through a mask.

Software controls the channel through a small register port. Mode bits pick the tick source and the counting behaviour. The counter can run free and wrap, or it can reset automatically when it matches compare C. A stop-on-C bit turns the channel into a one-shot. Command bits, kept separate from the mode, enable the tick, disable it, or restart the counter from zero. An external trigger input, when the mode allows it, restarts the counter in the same way.

Top module: `tc_chan`

## Requirements
- R1: After reset the counter reads 0, the tick is disabled, wave_out and irq are 0, and the mode (addr 1), compare A (addr 2), compare C (addr 3), status (addr 5) and mask (addr 8) registers all read 0. Reads return the addressed value one clock after rd_en.
- R2: With mode bit 3 clear (free run), the counter (addr 4) rises by one on each enabled tick and wraps from 0xFFFF to 0. The wrap sets status bit 2.
- R3: With mode bit 3 set, a tick while the counter equals compare C loads 0, so the period is C+1 ticks, and sets status bit 1. A tick while the counter equals compare A sets status bit 0, in either mode.
- R4: With mode bit 4 set, a compare C event disables the tick and the counter holds its value. A later enable command restarts counting.
- R5: A write to the command register (addr 0) acts on three bits: bit 0 enables the tick, bit 1 disables it, and bit 2 loads the counter and prescaler with 0. If bits 0 and 1 are written together, the disable wins. While the tick is disabled, the counter does not change except through bit 2.
- R6: Mode bits [2:0] select the count tick. 0 gives the system clock divided by 2, 1 divides by 8, 2 by 32 and 3 by 128. 4 selects slow_tick pulses, 5 selects synchronized rising edges of ext_clk, and 6 or 7 selects every system clock.
- R7: Each event drives wave_out through a two-bit action field: mode bits [6:5] for compare A and [8:7] for compare C. The encodings are 0 none, 1 set, 2 clear and 3 toggle. When both compares fire on the same tick and the C action is not none, only the C action applies.
- R8: Writing to addr 6 sets the mask bits that are 1 in the data. Writing to addr 7 clears the mask bits that are 1 in the data. The mask reads back at addr 8, with bit positions matching the status register.
- R9: irq is high exactly while some status bit and its mask bit are both 1.
- R10: Reading the status register returns the flags and clears them. A flag whose event occurs in the same cycle as the read stays set.
- R11: With mode bit 9 set, a rising edge on ext_trig, after a two-flop synchronizer, loads the counter with 0 (the count is 0 three clocks after the pin rises). With mode bit 9 clear, ext_trig has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Single-cycle slow-clock tick pulse |
| ext_clk | input | 1 | Asynchronous external count input |
| ext_trig | input | 1 | Asynchronous external trigger input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid one clock after rd_en |
| wave_out | output | 1 | Waveform output driven by compare actions |
| irq | output | 1 | Interrupt request |

## Verification
The case that is hardest to reach from the ports is the wrap of the free-running counter, and with it a status read that lands in the same cycle as the overflow event. No register lets the bench preload the count. The bench therefore restarts the counter on the undivided clock and waits through the full 65536-count span. It places its status read on the exact cycle in which the counter sits at 0xFFFF, so the clear and the overflow event meet. One-shot stop and the A/C action priority are reached by programming equal compare values and letting the count arrive there from a trigger at a known cycle.

// File: rtl/tc_chan.sv
module tc_chan #(
  parameter int CW = 16,
  parameter int AW = 4,
  parameter int PW = 7,
  parameter int D0 = 1,
  parameter int D1 = 3,
  parameter int D2 = 5,
  parameter int D3 = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          ext_clk,
  input  logic          ext_trig,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          wave_out,
  output logic          irq
);
  localparam int MW = 10;
  localparam int NF = 3;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [PW-1:0] M0 = PW'((1 << D0) - 1);
  localparam logic [PW-1:0] M1 = PW'((1 << D1) - 1);
  localparam logic [PW-1:0] M2 = PW'((1 << D2) - 1);
  localparam logic [PW-1:0] M3 = PW'((1 << D3) - 1);
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);
  localparam logic [AW-1:0] A_RA   = AW'(2);
  localparam logic [AW-1:0] A_RC   = AW'(3);
  localparam logic [AW-1:0] A_CNT  = AW'(4);
  localparam logic [AW-1:0] A_STS  = AW'(5);
  localparam logic [AW-1:0] A_IEN  = AW'(6);
  localparam logic [AW-1:0] A_IDIS = AW'(7);
  localparam logic [AW-1:0] A_MSK  = AW'(8);

  logic [CW-1:0] cnt, ra, rc;
  logic [MW-1:0] mode;
  logic [PW-1:0] pre;
  logic [NF-1:0] sts, imask;
  logic [2:0]    xs, ts;
  logic          clken, tick;

  logic wr_cmd, cmd_on, cmd_off, sw_trig, trig, run;
  logic ext_edge, trig_edge, rd_sr;
  logic auto_m, stop_m, ra_hit, rc_hit, ra_ev, rc_ev, ovf_ev;
  logic [1:0] ra_act, rc_act;

  assign wr_cmd    = wr_en && addr == A_CMD;
  assign cmd_on    = wr_cmd & wdata[0];
  assign cmd_off   = wr_cmd & wdata[1];
  assign sw_trig   = wr_cmd & wdata[2];
  assign ext_edge  = xs[1] & ~xs[2];
  assign trig_edge = ts[1] & ~ts[2];
  assign trig      = sw_trig | (mode[9] & trig_edge);
  assign auto_m    = mode[3];
  assign stop_m    = mode[4];
  assign ra_act    = mode[6:5];
  assign rc_act    = mode[8:7];
  assign rd_sr     = rd_en && addr == A_STS;

  always_comb begin
    case (mode[2:0])
      3'd0:    tick = (pre & M0) == M0;
      3'd1:    tick = (pre & M1) == M1;
      3'd2:    tick = (pre & M2) == M2;
      3'd3:    tick = (pre & M3) == M3;
      3'd4:    tick = slow_tick;
      3'd5:    tick = ext_edge;
      default: tick = 1'b1;
    endcase
  end

  assign run    = clken & tick & ~trig;
  assign ra_hit = cnt == ra;
  assign rc_hit = cnt == rc;
  assign ra_ev  = run & ra_hit;
  assign rc_ev  = run & rc_hit;
  assign ovf_ev = run & (cnt == CMAX) & ~(auto_m & rc_hit);
  assign irq    = |(sts & imask);

  function automatic logic act(input logic [1:0] a, input logic w);
    case (a)
      2'd1:    act = 1'b1;
      2'd2:    act = 1'b0;
      2'd3:    act = ~w;
      default: act = w;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs <= '0;
      ts <= '0;
      pre <= '0;
    end else begin
      xs <= {xs[1:0], ext_clk};
      ts <= {ts[1:0], ext_trig};
      pre <= trig ? '0 : pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      clken <= 1'b0;
      wave_out <= 1'b0;
    end else begin
      if (trig) cnt <= '0;
      else if (run) cnt <= (auto_m && rc_hit) ? '0 : cnt + 1'b1;

      if (cmd_off) clken <= 1'b0;
      else if (cmd_on) clken <= 1'b1;
      else if (rc_ev && stop_m) clken <= 1'b0;

      if (rc_ev && rc_act != 2'd0) wave_out <= act(rc_act, wave_out);
      else if (ra_ev) wave_out <= act(ra_act, wave_out);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      ra <= '0;
      rc <= '0;
      imask <= '0;
      sts <= '0;
      rdata <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_MODE:  mode <= wdata[MW-1:0];
          A_RA:    ra <= wdata;
          A_RC:    rc <= wdata;
          A_IEN:   imask <= imask | wdata[NF-1:0];
          A_IDIS:  imask <= imask & ~wdata[NF-1:0];
          default: ;
        endcase
      end
      sts <= (rd_sr ? '0 : sts) | {ovf_ev, rc_ev, ra_ev};
      if (rd_en) begin
        case (addr)
          A_MODE:  rdata <= CW'(mode);
          A_RA:    rdata <= ra;
          A_RC:    rdata <= rc;
          A_CNT:   rdata <= cnt;
          A_STS:   rdata <= CW'(sts);
          A_MSK:   rdata <= CW'(imask);
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tc_chan_chk.sv
module tc_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          clken,
  input logic          trig,
  input logic          run,
  input logic          auto_m,
  input logic          stop_m,
  input logic          rc_hit,
  input logic          rc_ev,
  input logic          ra_ev,
  input logic          cmd_on,
  input logic          cmd_off,
  input logic          rd_sr,
  input logic [2:0]    ev,
  input logic [2:0]    sts,
  input logic          wave_out
);
  // R5
  off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off |=> !clken);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken && !trig) |=> cnt == $past(cnt));

  // R5
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cnt == '0);

  // R2
  free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !auto_m) |=> cnt == CW'($past(cnt) + 1'b1));

  // R3
  auto_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && auto_m && rc_hit) |=> cnt == '0);

  // R4
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_ev && stop_m && !cmd_on) |=> !clken);

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sr && ev == 3'b000) |=> sts == 3'b000);

  // R7
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_ev && !rc_ev) |=> wave_out == $past(wave_out));
endmodule

bind tc_chan tc_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .clken(clken), .trig(trig), .run(run),
  .auto_m(auto_m), .stop_m(stop_m), .rc_hit(rc_hit), .rc_ev(rc_ev), .ra_ev(ra_ev),
  .cmd_on(cmd_on), .cmd_off(cmd_off), .rd_sr(rd_sr), .ev({ovf_ev, rc_ev, ra_ev}),
  .sts(sts), .wave_out(wave_out)
);

// File: tb/tc_chan_tb_top.sv
module tc_chan_tb_top;
  localparam int TCLK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0, ext_clk = 1'b0, ext_trig = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic wave_out, irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic rd_q = 1'b0, pin_q = 1'b0, pin_req = 1'b0;

  typedef struct {bit is_pin; logic [15:0] v; string tag;} exp_t;
  exp_t q[$];

  always #(TCLK/2) clk = ~clk;

  tc_chan dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ext_clk(ext_clk),
    .ext_trig(ext_trig), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wave_out(wave_out), .irq(irq)
  );

  always @(posedge clk) begin
    rd_q <= rd_en;
    pin_q <= pin_req;
  end

  always @(negedge clk) begin
    if (rd_q || pin_q) begin
      exp_t e;
      logic [15:0] got;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: actual result with no expectation, expected none");
      end else begin
        e = q.pop_front();
        got = e.is_pin ? {14'd0, wave_out, irq} : rdata;
        if (got !== e.v) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", e.tag, got, e.v);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] ev, input string tag);
    exp_t e;
    e.is_pin = 1'b0; e.v = ev; e.tag = tag;
    q.push_back(e);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pins(input logic w, input logic i, input string tag);
    exp_t e;
    e.is_pin = 1'b1; e.v = {14'd0, w, i}; e.tag = tag;
    q.push_back(e);
    pin_req = 1'b1;
    @(negedge clk);
    pin_req = 1'b0;
  endtask

  task automatic slow_pulse();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1; idle(3);
    ext_clk = 1'b0; idle(3);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual run still busy, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(4, 16'd0, "R1 counter");
    rd(5, 16'd0, "R1 status");
    rd(8, 16'd0, "R1 mask");
    rd(1, 16'd0, "R1 mode");
    pins(1'b0, 1'b0, "R1 pins");

    // R2 free run on undivided clock
    wr(1, 16'h0006);
    wr(0, 16'h0005);
    idle(9);
    rd(4, 16'd9, "R2 count");
    wr(0, 16'h0002);
    rd(4, 16'd11, "R5 disable holds");
    wr(0, 16'h0003);
    idle(3);
    rd(4, 16'd11, "R5 disable wins");

    // R2 wrap, R10 same-cycle event
    rd(5, 16'd3, "R3 compare flags at 0");
    wr(0, 16'h0005);
    idle(65534);
    rd(4, 16'hFFFE, "R2 near top");
    rd(5, 16'd3, "R10 read at wrap");
    rd(4, 16'd0, "R2 wrapped");
    rd(5, 16'd7, "R10 overflow kept R2");
    rd(5, 16'd0, "R10 cleared");
    wr(0, 16'h0002);

    // R3 auto reset
    wr(2, 16'd2);
    wr(3, 16'd4);
    wr(1, 16'h000E);
    rd(5, 16'd0, "R3 flags clear");
    wr(0, 16'h0005);
    idle(4);
    rd(4, 16'd4, "R3 at C");
    rd(4, 16'd0, "R3 reset to 0");
    rd(5, 16'd3, "R3 A and C flags");
    rd(4, 16'd2, "R3 next period");
    wr(0, 16'h0002);

    // R7 set on A, clear on C
    wr(1, 16'h012E);
    wr(0, 16'h0005);
    idle(2);
    pins(1'b1, 1'b0, "R7 set on A");
    pins(1'b1, 1'b0, "R7 held");
    pins(1'b0, 1'b0, "R7 clear on C");
    wr(0, 16'h0002);
    // R7 priority: A set, C toggle, same value
    wr(2, 16'd4);
    wr(1, 16'h01AE);
    wr(0, 16'h0005);
    idle(4);
    pins(1'b1, 1'b0, "R7 C toggle wins");
    idle(4);
    pins(1'b0, 1'b0, "R7 C toggle again");
    wr(0, 16'h0002);

    // R4 one-shot
    wr(1, 16'h001E);
    rd(5, 16'd3, "R3 flags before one-shot");
    wr(0, 16'h0005);
    idle(4);
    rd(4, 16'd4, "R4 at C");
    rd(4, 16'd0, "R4 stopped");
    idle(5);
    rd(4, 16'd0, "R4 still stopped");
    wr(0, 16'h0005);
    idle(2);
    rd(4, 16'd2, "R4 restarted");
    wr(0, 16'h0002);

    // R8 R9 interrupts
    wr(6, 16'h0002);
    pins(1'b0, 1'b1, "R9 irq on C flag");
    wr(7, 16'h0002);
    pins(1'b0, 1'b0, "R9 masked off");
    rd(8, 16'd0, "R8 mask cleared");
    wr(6, 16'h0005);
    rd(8, 16'd5, "R8 mask set");
    pins(1'b0, 1'b1, "R9 irq on A flag");
    rd(5, 16'd3, "R10 read flags");
    pins(1'b0, 1'b0, "R10 irq drops after read");
    wr(7, 16'h00FF);
    rd(8, 16'd0, "R8 disable all");

    // R6 tick selection
    wr(1, 16'h0001);
    wr(0, 16'h0005);
    idle(16);
    rd(4, 16'd2, "R6 divide by 8");
    wr(0, 16'h0002);
    wr(1, 16'h0000);
    wr(0, 16'h0005);
    idle(16);
    rd(4, 16'd8, "R6 divide by 2");
    wr(0, 16'h0002);
    wr(1, 16'h0004);
    wr(0, 16'h0005);
    slow_pulse(); slow_pulse(); slow_pulse();
    rd(4, 16'd3, "R6 slow tick");
    wr(0, 16'h0002);
    wr(1, 16'h0005);
    wr(0, 16'h0005);
    ext_pulse(); ext_pulse(); ext_pulse();
    idle(3);
    rd(4, 16'd3, "R6 external edges");
    wr(0, 16'h0002);

    // R11 external trigger
    wr(1, 16'h0206);
    wr(0, 16'h0005);
    idle(10);
    ext_trig = 1'b1;
    idle(6);
    rd(4, 16'd3, "R11 trigger restarts");
    ext_trig = 1'b0;
    idle(3);
    wr(0, 16'h0002);
    wr(1, 16'h0006);
    wr(0, 16'h0005);
    ext_trig = 1'b1;
    idle(6);
    rd(4, 16'd6, "R11 trigger ignored");
    ext_trig = 1'b0;

    idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule